// File: doc/BRIEF.md
# Dual-Mode SPI Controller

This block is a byte-wide SPI engine that a processor drives through a small synchronous register port. It has a control register, a status register and a data register. One control bit decides the role. As a bus master, the block makes SCK from the peripheral clock through a selectable divider and starts a byte when software writes the data register. As a slave, it follows an external SCK while an active-low select input is held low. The slave brings SCK, select and MOSI into the peripheral clock domain through synchronizers, so the external SCK may run at no more than a quarter of the peripheral clock.

A single 8-bit shift register carries both the outgoing and the incoming byte. Each finished byte is copied into a separate receive buffer, and a completion flag is raised at the same time. Software clears the flag with a fixed read sequence. If a slave has not been loaded before the remote master clocks it, it sends back whatever the shift register still holds. Configuration fields other than the enable bit can only change while the block is disabled. Clearing the enable bit stops all activity at once.

Top module: `spi_dual_ctrl`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) both read 0x00. SCK output is low, and none of the three output enables (sck_oe, mosi_oe, miso_oe) is asserted.
- R2: The control register holds these fields: bit 0 is enable, bit 1 is master, bit 2 is clock polarity, bit 3 is clock phase, and bits 5:4 are the rate. Bits 7:6 read as zero. While enable reads 1, a write to the control register changes only bit 0. While enable is 0, every field is writable.
- R3: Write the data register (address 2) while the block is enabled, in master mode and idle. This starts a byte, and sck_o then makes exactly 16 transitions. Each half period lasts 2<<rate peripheral clocks, which gives SCK at the peripheral clock divided by 4, 8, 16 or 32. sck_oe and mosi_oe are high whenever the block is enabled as master.
- R4: When no byte is in progress, SCK rests at the polarity level. Data moves most significant bit first. With phase 0, each bit is valid before the first SCK edge of its bit time and is sampled on that edge. With phase 1, each bit changes on the first edge and is sampled on the second edge.
- R5: At the end of every byte, status bit 7 (the completion flag) is set. In the same cycle, the received byte is stored where a read of address 2 returns it.
- R6: The completion flag clears only when a read of address 1 that sees the flag set is later followed by a read of address 2. A read of address 2 with no such status read first leaves the flag set.
- R7: In master mode, a data write is ignored in two cases: while a byte is in progress, and while the block is disabled.
- R8: In slave mode, SCK edges count only while ss_n_i is low. If ss_n_i goes high partway through a byte, the partial bit count is dropped and no flag is raised. miso_oe is high only when the block is enabled, in slave mode and selected.
- R9: In slave mode, a data write loads the shift register only when no bit of the current byte has yet been captured. A write made after that is ignored. A byte with no new load sends the byte received previously.
- R10: In slave mode, suppose a byte completes while the completion flag is still set. Then status bit 6 (overrun) is set, and the receive buffer keeps the older byte. Overrun clears through the same sequence as the flag.
- R11: Clearing the enable bit in the middle of a byte has these effects: the byte is abandoned with no flag, SCK returns to the polarity level, and the output enables drop. The next byte after re-enabling then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe (status/data side effects) |
| reg_rdata | output | 8 | Read data for reg_addr |
| sck_o | output | 1 | SCK driven in master mode |
| sck_oe | output | 1 | SCK output enable |
| sck_i | input | 1 | SCK received in slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_oe | output | 1 | MOSI output enable |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_oe | output | 1 | MISO output enable (released when not driving) |
| miso_i | input | 1 | Serial data in for master mode |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The hardest state to reach from the ports is a slave shift register that holds stale or partly shifted data. A load is ignored only if it arrives after the first capture of a byte. An overrun needs a second full byte to finish while the flag is still set. The bench plays the remote master on sck_i, mosi_i and ss_n_i. It issues the data write partway through a byte, skips the flag-clearing reads before the next byte, and raises select after four bits. Each of these situations then shows up at the ports: in the bits captured from miso_o and in the status and data read back.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;

  typedef struct packed {
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } spi_cfg_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // peripheral clocks per SCK half period: 2, 4, 8, 16
  function automatic logic [4:0] half_len(input logic [1:0] rate);
    return 5'd2 << rate;
  endfunction

  // capture happens on the first edge for phase 0, on the second for phase 1
  function automatic logic is_capture(input logic lead, input logic cpha);
    return lead ^ cpha;
  endfunction

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_dual_pkg::*;
#(
  parameter int DW = 8,
  parameter int HW = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cpol,
  input  logic [1:0] rate,
  input  logic       start,
  output logic       busy,
  output logic       sck,
  output logic       tick,
  output logic       tick_lead
);
  localparam int NEDGE = 2 * DW;
  localparam int EW    = $clog2(NEDGE);

  logic [HW-1:0] hcnt;
  logic [EW-1:0] ecnt;
  logic          hdone;

  assign hdone     = (hcnt == HW'(half_len(rate) - 5'd1));
  assign tick      = busy & hdone;
  assign tick_lead = ~ecnt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hcnt <= '0;
      ecnt <= '0;
      sck  <= 1'b0;
    end else if (!en) begin
      busy <= 1'b0;
      hcnt <= '0;
      ecnt <= '0;
      sck  <= cpol;
    end else if (start && !busy) begin
      busy <= 1'b1;
      hcnt <= '0;
      ecnt <= '0;
      sck  <= cpol;
    end else if (busy) begin
      if (hdone) begin
        hcnt <= '0;
        sck  <= ~sck;
        ecnt <= ecnt + 1'b1;
        if (ecnt == EW'(NEDGE - 1)) busy <= 1'b0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end else begin
      sck <= cpol;
    end
  end
endmodule

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpol,
  input  logic sck_i,
  input  logic ss_n_i,
  input  logic din_i,
  output logic sel,
  output logic din,
  output logic tick,
  output logic tick_lead
);
  logic [STAGES:0]   sck_s;
  logic [STAGES-1:0] ss_s;
  logic [STAGES-1:0] d_s;
  logic              rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      ss_s  <= '1;
      d_s   <= '0;
    end else begin
      sck_s <= {sck_s[STAGES-1:0], sck_i};
      ss_s  <= {ss_s[STAGES-2:0], ss_n_i};
      d_s   <= {d_s[STAGES-2:0], din_i};
    end
  end

  assign rise      = sck_s[STAGES-1] & ~sck_s[STAGES];
  assign fall      = ~sck_s[STAGES-1] & sck_s[STAGES];
  assign sel       = ~ss_s[STAGES-1];
  assign din       = d_s[STAGES-1];
  assign tick      = sel & (rise | fall);
  assign tick_lead = cpol ? fall : rise;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_dual_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] ldata,
  input  logic          tick,
  input  logic          tick_lead,
  input  logic          cpha,
  input  logic          din,
  output logic          dout,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sreg;
  logic [CW-1:0] cnt;
  logic          cap, launch;

  assign cap     = tick & is_capture(tick_lead, cpha);
  assign launch  = tick & ~is_capture(tick_lead, cpha);
  assign rx_word = {sreg[DW-2:0], din};
  assign done    = cap && (cnt == CW'(DW - 1)) && !clr;
  assign idle    = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      dout <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      sreg <= ldata;
      dout <= ldata[DW-1];
      cnt  <= '0;
    end else begin
      if (cap) begin
        sreg <= rx_word;
        cnt  <= (cnt == CW'(DW - 1)) ? '0 : cnt + 1'b1;
      end
      if (launch) dout <= sreg[DW-1];
      if (clr) cnt <= '0;
    end
  end
endmodule

// File: rtl/spi_dual_ctrl.sv
module spi_dual_ctrl
  import spi_dual_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_we,
  input  logic          reg_re,
  output logic [DW-1:0] reg_rdata,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          miso_i,
  input  logic          ss_n_i
);
  localparam int CFGW = $bits(spi_cfg_t);

  spi_cfg_t      cfg;
  logic          flag, ovr, armed;
  logic [DW-1:0] rx_buf;

  logic ctl_wr, dat_wr, stat_rd, data_rd;
  logic m_busy, m_sck, m_tick, m_lead;
  logic s_sel, s_din, s_tick, s_lead;
  logic sh_tick, sh_lead, sh_din, sh_clr, sh_load, sh_idle, sh_dout, xfer_done;
  logic [DW-1:0] rx_word;

  assign ctl_wr  = reg_we && (reg_addr == ADDR_CTRL);
  assign dat_wr  = reg_we && (reg_addr == ADDR_DATA);
  assign stat_rd = reg_re && (reg_addr == ADDR_STAT);
  assign data_rd = reg_re && (reg_addr == ADDR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (ctl_wr) begin
      cfg.en <= reg_wdata[0];
      if (!cfg.en) begin
        cfg.master <= reg_wdata[1];
        cfg.cpol   <= reg_wdata[2];
        cfg.cpha   <= reg_wdata[3];
        cfg.rate   <= reg_wdata[5:4];
      end
    end
  end

  spi_clkgen #(.DW(DW)) i_clkgen (
    .clk(clk), .rst_n(rst_n), .en(cfg.en & cfg.master), .cpol(cfg.cpol),
    .rate(cfg.rate), .start(dat_wr), .busy(m_busy), .sck(m_sck),
    .tick(m_tick), .tick_lead(m_lead)
  );

  spi_edge_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .cpol(cfg.cpol), .sck_i(sck_i), .ss_n_i(ss_n_i),
    .din_i(mosi_i), .sel(s_sel), .din(s_din), .tick(s_tick), .tick_lead(s_lead)
  );

  assign sh_tick = cfg.master ? m_tick : (s_tick & cfg.en);
  assign sh_lead = cfg.master ? m_lead : s_lead;
  assign sh_din  = cfg.master ? miso_i : s_din;
  assign sh_clr  = !cfg.en || (!cfg.master && !s_sel);
  assign sh_load = dat_wr && (cfg.master ? (cfg.en && !m_busy) : sh_idle);

  spi_shifter #(.DW(DW)) i_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load(sh_load), .ldata(reg_wdata),
    .tick(sh_tick), .tick_lead(sh_lead), .cpha(cfg.cpha), .din(sh_din),
    .dout(sh_dout), .idle(sh_idle), .done(xfer_done), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      ovr    <= 1'b0;
      armed  <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (data_rd && armed) begin
        flag  <= 1'b0;
        ovr   <= 1'b0;
        armed <= 1'b0;
      end else if (stat_rd && flag) begin
        armed <= 1'b1;
      end
      if (xfer_done) begin
        flag <= 1'b1;
        if (flag && !cfg.master) ovr <= 1'b1;
        else                     rx_buf <= rx_word;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {{(DW - CFGW){1'b0}}, cfg};
      ADDR_STAT: reg_rdata = {flag, ovr, {(DW - 2){1'b0}}};
      ADDR_DATA: reg_rdata = rx_buf;
      default:   reg_rdata = '0;
    endcase
  end

  assign sck_o   = m_sck;
  assign sck_oe  = cfg.en & cfg.master;
  assign mosi_o  = sh_dout;
  assign mosi_oe = cfg.en & cfg.master;
  assign miso_o  = sh_dout;
  assign miso_oe = cfg.en & ~cfg.master & s_sel;
endmodule

// File: rtl/spi_dual_chk.sv
module spi_dual_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          master,
  input logic          cpol,
  input logic          cpha,
  input logic [1:0]    rate,
  input logic          busy,
  input logic          sck_o,
  input logic          xfer_done,
  input logic          flag,
  input logic          ovr,
  input logic          armed,
  input logic          data_rd,
  input logic          slv_sel,
  input logic [DW-1:0] rx_buf
);
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) |-> $stable({master, cpol, cpha, rate}));

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && master && $past(master) && !busy |-> sck_o == cpol);

  assert_flag_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> flag);

  assert_clear_sequence_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(data_rd && armed));

  assert_quiet_unselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !master && !slv_sel |-> !xfer_done);

  assert_keep_old_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && flag && !master |=> $stable(rx_buf) && ovr);
endmodule

bind spi_dual_ctrl spi_dual_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(cfg.en), .master(cfg.master), .cpol(cfg.cpol),
  .cpha(cfg.cpha), .rate(cfg.rate), .busy(m_busy), .sck_o(sck_o),
  .xfer_done(xfer_done), .flag(flag), .ovr(ovr), .armed(armed),
  .data_rd(data_rd), .slv_sel(s_sel), .rx_buf(rx_buf)
);

// File: tb/test_spi_dual_ctrl.sv
module test_spi_dual_ctrl;
  localparam int H = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_rdata;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1, inv = 1'b0;
  logic       miso_i;
  assign miso_i = inv ? ~mosi_o : mosi_o;

  spi_dual_ctrl i_spi_dual_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  int total = 0, bad = 0;
  logic finished = 1'b0;

  // SCK monitor acting as the remote slave for master tests
  logic mon_clr = 1'b0, cur_cpol = 1'b0, cur_cpha = 1'b0, sck_prev = 1'b0;
  int   ecount = 0, cyc = 0, t0 = 0, t1 = 0;
  logic [7:0] mcap = '0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      ecount <= 0; mcap <= '0;
    end else if (sck_o !== sck_prev) begin
      ecount <= ecount + 1;
      if (ecount == 0) t0 <= cyc;
      if (ecount == 1) t1 <= cyc;
      if ((sck_o != cur_cpol) == (cur_cpha == 1'b0)) mcap <= {mcap[6:0], mosi_o};
    end
    sck_prev <= sck_o;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    #2 v = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic clear_flag();
    logic [7:0] v;
    rd(2'd1, v); rd(2'd2, v);
  endtask

  // remote master model for slave tests
  task automatic slave_xfer(input logic [7:0] mo, input logic pol, input logic pha,
                            input int nbits, input logic late, input logic [7:0] late_d,
                            output logic [7:0] got);
    got = '0;
    @(negedge clk); sck_i = pol; ss_n_i = 1'b0;
    waitc(H);
    for (int i = 0; i < nbits; i++) begin
      if (!pha) begin
        mosi_i = mo[7-i];
        if (late && i == 2) wr(2'd2, late_d);
        waitc(H);
        got[7-i] = miso_o;
        sck_i = ~pol;
        waitc(H);
        sck_i = pol;
      end else begin
        sck_i = ~pol;
        mosi_i = mo[7-i];
        if (late && i == 2) wr(2'd2, late_d);
        waitc(H);
        got[7-i] = miso_o;
        sck_i = pol;
        waitc(H);
      end
    end
    waitc(H);
    ss_n_i = 1'b1;
    waitc(H);
  endtask

  // {cpol, cpha, rate[1:0], invert, data[7:0]}
  localparam logic [12:0] MVEC [8] = '{
    {1'b0, 1'b0, 2'd0, 1'b0, 8'hA5},
    {1'b0, 1'b1, 2'd1, 1'b0, 8'h3C},
    {1'b1, 1'b0, 2'd2, 1'b0, 8'h81},
    {1'b1, 1'b1, 2'd3, 1'b0, 8'h7E},
    {1'b0, 1'b0, 2'd1, 1'b1, 8'h5A},
    {1'b1, 1'b1, 2'd0, 1'b1, 8'h00},
    {1'b0, 1'b1, 2'd3, 1'b0, 8'hFF},
    {1'b1, 1'b0, 2'd0, 1'b1, 8'hC3}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, got;
    waitc(3);
    rst_n = 1'b1;
    waitc(2);

    // R1 reset state
    rd(2'd0, v); chk(v, 8'h00, "R1 ctrl after reset");
    rd(2'd1, v); chk(v, 8'h00, "R1 status after reset");
    chk({sck_o, sck_oe, mosi_oe, miso_oe}, 4'b0000, "R1 pins after reset");

    // R2 field layout and guard
    wr(2'd0, 8'hFF); rd(2'd0, v); chk(v, 8'h3F, "R2 all fields written while disabled");
    wr(2'd0, 8'h01); rd(2'd0, v); chk(v, 8'h3F, "R2 fields held while enabled");
    wr(2'd0, 8'h00); rd(2'd0, v); chk(v, 8'h3E, "R2 only enable bit cleared");

    // R3 R4 R5 R6 master vectors with loopback slave
    for (int k = 0; k < 8; k++) begin
      logic [12:0] vec;
      logic [7:0]  cw, expd;
      vec = MVEC[k];
      cur_cpol = vec[12]; cur_cpha = vec[11]; inv = vec[8];
      cw = {2'b00, vec[10:9], vec[11], vec[12], 2'b10};
      wr(2'd0, cw);
      wr(2'd0, cw | 8'h01);
      mon_clr = 1'b1; waitc(3); mon_clr = 1'b0;
      chk(sck_o, vec[12], "R4 idle level before byte");
      chk({sck_oe, mosi_oe}, 2'b11, "R3 master output enables");
      wr(2'd2, vec[7:0]);
      waitc(16 * (2 << vec[10:9]) + 8);
      chk(ecount, 16, "R3 edge count");
      chk(t1 - t0, 2 << vec[10:9], "R3 half period");
      chk(mcap, vec[7:0], "R4 bits on mosi msb first");
      chk(sck_o, vec[12], "R4 idle level after byte");
      expd = vec[8] ? ~vec[7:0] : vec[7:0];
      rd(2'd1, v); chk(v, 8'h80, "R5 flag set");
      rd(2'd2, v); chk(v, expd, "R5 received byte");
      rd(2'd1, v); chk(v, 8'h00, "R6 flag cleared by sequence");
      wr(2'd0, cw);
    end

    // R6 data read alone does not clear; R7 write while busy ignored
    inv = 1'b0; cur_cpol = 1'b0; cur_cpha = 1'b0;
    wr(2'd0, 8'h02); wr(2'd0, 8'h03);
    mon_clr = 1'b1; waitc(3); mon_clr = 1'b0;
    wr(2'd2, 8'h12);
    waitc(10);
    wr(2'd2, 8'h34);
    waitc(80);
    chk(ecount, 16, "R7 no second byte from busy write");
    rd(2'd2, v); chk(v, 8'h12, "R7 busy write ignored");
    rd(2'd1, v); chk(v, 8'h80, "R6 data read alone keeps flag");
    rd(2'd2, v);
    rd(2'd1, v); chk(v, 8'h00, "R6 cleared after status then data");

    // R11 disable mid byte, then recovery
    wr(2'd0, 8'h36); wr(2'd0, 8'h37);
    cur_cpol = 1'b1; cur_cpha = 1'b1;
    wr(2'd2, 8'hB4);
    waitc(40);
    wr(2'd0, 8'h36);
    waitc(3);
    chk({sck_o, sck_oe, mosi_oe}, 3'b100, "R11 sck idle and enables dropped");
    waitc(300);
    rd(2'd1, v); chk(v, 8'h00, "R11 no flag from abandoned byte");
    wr(2'd2, 8'h55);
    waitc(300);
    rd(2'd1, v); chk(v, 8'h00, "R7 write while disabled ignored");
    wr(2'd0, 8'h37);
    wr(2'd2, 8'h69);
    waitc(300);
    rd(2'd1, v); chk(v, 8'h80, "R11 flag after re-enable");
    rd(2'd2, v); chk(v, 8'h69, "R11 byte after re-enable");

    // slave mode, cpol 0 cpha 0
    wr(2'd0, 8'h00); sck_i = 1'b0; waitc(4);
    wr(2'd0, 8'h01);
    chk(miso_oe, 1'b0, "R8 miso released while deselected");
    wr(2'd2, 8'h96);
    slave_xfer(8'h5B, 1'b0, 1'b0, 8, 1'b0, 8'h00, got);
    chk(got, 8'h96, "R8 slave sends loaded byte");
    rd(2'd1, v); chk(v, 8'h80, "R5 slave flag");
    rd(2'd2, v); chk(v, 8'h5B, "R5 slave received byte");
    slave_xfer(8'h11, 1'b0, 1'b0, 8, 1'b0, 8'h00, got);
    chk(got, 8'h5B, "R9 stale byte resent");
    clear_flag();
    slave_xfer(8'h22, 1'b0, 1'b0, 8, 1'b1, 8'hEE, got);
    chk(got, 8'h11, "R9 late write ignored");
    slave_xfer(8'h33, 1'b0, 1'b0, 8, 1'b0, 8'h00, got);
    chk(got, 8'h22, "R9 shift contents after late write");
    rd(2'd1, v); chk(v, 8'hC0, "R10 overrun flagged");
    rd(2'd2, v); chk(v, 8'h22, "R10 older byte kept");
    rd(2'd1, v); chk(v, 8'h00, "R10 overrun cleared with flag");

    // slave mode, cpol 1 cpha 1
    wr(2'd0, 8'h00); sck_i = 1'b1; waitc(4);
    wr(2'd0, 8'h0C); wr(2'd0, 8'h0D);
    wr(2'd2, 8'hA7);
    slave_xfer(8'h4C, 1'b1, 1'b1, 8, 1'b0, 8'h00, got);
    chk(got, 8'hA7, "R4 slave phase 1 transmit");
    rd(2'd1, v); rd(2'd2, v); chk(v, 8'h4C, "R4 slave phase 1 receive");
    slave_xfer(8'hF0, 1'b1, 1'b1, 4, 1'b0, 8'h00, got);
    rd(2'd1, v); chk(v, 8'h00, "R8 partial byte gives no flag");
    waitc(2 * H); sck_i = 1'b1; waitc(4);
    sck_i = 1'b0; waitc(H); sck_i = 1'b1; waitc(4);
    rd(2'd1, v); chk(v, 8'h00, "R8 edges ignored while deselected");
    slave_xfer(8'h3D, 1'b1, 1'b1, 8, 1'b0, 8'h00, got);
    rd(2'd1, v); chk(v, 8'h80, "R8 full byte after abort");
    rd(2'd2, v); chk(v, 8'h3D, "R8 count restarted after abort");

    // R11 slave disabled releases miso even when selected
    wr(2'd0, 8'h0C);
    ss_n_i = 1'b0; waitc(4);
    chk(miso_oe, 1'b0, "R11 miso released when disabled");
    ss_n_i = 1'b1; waitc(2);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule